// File: doc/BRIEF.md
# Streaming Elementwise Matrix Sum Pipeline

This block adds two square integer matrices element by element and is fed by a stream of two-dimensional work-item identifiers. Each identifier names one element: the second coordinate is the row and the first is the column. For each identifier the block forms the flat element index `row*N + col`. It reads the two operands at that index through two read ports with a fixed latency. It writes their sum to the result memory at the same index through a write port.

The pipeline has four stages: index formation, two read-latency stages, and a sum/store stage. When the write port accepts every cycle, it takes one identifier per clock. If the write port refuses a result, every stage freezes together. The read ports take their pipeline enable from the block, so operand data stays aligned with the identifiers in flight. After the `N*N`-th completed write the block raises a completion pulse for one cycle. It then starts counting again for the next sweep. `N` must be a power of two, so the row scaling is a shift and the flat index is the row bits joined above the column bits.

Top module: `mxadd_pipe`

## Requirements
- R1: When an identifier is accepted (`id_valid && id_ready` at a clock edge), both read ports present it after that edge with the enable high and address `gid1*N + gid0`.
- R2: Each write carries the address of its identifier and the data `(A[idx] + B[idx]) mod 2^DW`, where A and B are the operand memory contents at that index.
- R3: With `wr_ready` held high, `id_ready` stays high and one identifier is accepted per clock. The write for an identifier accepted at edge k is presented after edge k+3.
- R4: Read ports advance only on clocks where `rd_step` is high. Operand data is expected on `rda_data`/`rdb_data` exactly two such steps after the request.
- R5: While a result is presented and `wr_ready` is low, `id_ready` and `rd_step` are low and `wr_en`, `wr_addr` and `wr_data` hold. No identifier is lost or written twice.
- R6: Writes complete in the order the identifiers were accepted.
- R7: `done` is high for exactly one cycle, the cycle after the edge where the `N*N`-th write since reset or since the previous pulse completes (`wr_en && wr_ready`).
- R8: During and just after reset `wr_en`, `rda_en`, `rdb_en` and `done` are low and `id_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Identifier present |
| id_ready | output | 1 | Identifier taken at this edge when valid |
| gid0 | input | log2(N) | Column coordinate |
| gid1 | input | log2(N) | Row coordinate |
| rd_step | output | 1 | Pipeline enable for both read ports |
| rda_en | output | 1 | Operand A read request |
| rda_addr | output | 2*log2(N) | Operand A flat index |
| rda_data | input | DW | Operand A data, two steps after request |
| rdb_en | output | 1 | Operand B read request |
| rdb_addr | output | 2*log2(N) | Operand B flat index |
| rdb_data | input | DW | Operand B data, two steps after request |
| wr_en | output | 1 | Result write present |
| wr_addr | output | 2*log2(N) | Result flat index |
| wr_data | output | DW | Sum |
| wr_ready | input | 1 | Result memory takes the write |
| done | output | 1 | One-cycle pulse after the last write of a sweep |

## Verification
Assertions check several properties on every cycle: the address presented after each accepted identifier, that a refused write holds, that the delay line stays frozen without a step, and that `done` is a lone pulse that follows a completed write. Only the bench's scenarios show arithmetic correctness with wrap-around, ordering and absence of loss or duplication over whole sweeps, and the exact four-edge latency. They also show that the completion pulse lands after the `N*N`-th write. The sweeps run in row-major, column-major and reverse order, with and without input gaps and write back-pressure.

// File: rtl/mxadd_pkg.sv
package mxadd_pkg;

    // Default read-port latency in pipeline steps.
    localparam int RD_LAT_DEF = 2;

    // Flat element index: row bits sit above column bits (N is a power of two).
    function automatic logic [31:0] flat_index(input logic [31:0] row,
                                               input logic [31:0] col,
                                               input int unsigned lg);
        return (row << lg) | col;
    endfunction

endpackage

// File: rtl/mxadd_addr.sv
module mxadd_addr #(
    parameter int N  = 4,
    localparam int LGN = $clog2(N),
    localparam int AW  = 2 * LGN
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step,
    input  logic           id_valid,
    input  logic [LGN-1:0] gid0,
    input  logic [LGN-1:0] gid1,
    output logic           s_valid,
    output logic [AW-1:0]  s_addr
);
    typedef struct packed {
        logic          v;
        logic [AW-1:0] a;
    } addr_st_t;

    addr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            st_d.v = id_valid;
            st_d.a = AW'(mxadd_pkg::flat_index(32'(gid1), 32'(gid0), LGN));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s_valid = st_q.v;
    assign s_addr  = st_q.a;

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(s_valid) && $stable(s_addr));
endmodule

// File: rtl/mxadd_delay.sv
module mxadd_delay #(
    parameter int AW  = 4,
    parameter int LAT = mxadd_pkg::RD_LAT_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          in_v,
    input  logic [AW-1:0] in_a,
    output logic          out_v,
    output logic [AW-1:0] out_a
);
    typedef struct packed {
        logic          v;
        logic [AW-1:0] a;
    } slot_t;

    slot_t line_d [LAT];
    slot_t line_q [LAT];

    always_comb begin
        for (int i = 0; i < LAT; i++) line_d[i] = line_q[i];
        if (step) begin
            line_d[0].v = in_v;
            line_d[0].a = in_a;
            for (int i = 1; i < LAT; i++) line_d[i] = line_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < LAT; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n) line_q[g] <= '0;
                else        line_q[g] <= line_d[g];
            end
        end
    endgenerate

    assign out_v = line_q[LAT-1].v;
    assign out_a = line_q[LAT-1].a;

    // R4
    delay_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(out_v) && $stable(out_a));
endmodule

// File: rtl/mxadd_store.sv
module mxadd_store #(
    parameter int DW    = 16,
    parameter int AW    = 4,
    parameter int TOTAL = 16,
    localparam int CW   = $clog2(TOTAL) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_v,
    input  logic [AW-1:0] in_a,
    input  logic [DW-1:0] a_data,
    input  logic [DW-1:0] b_data,
    input  logic          wr_ready,
    output logic          step,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          done
);
    typedef struct packed {
        logic          v;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic [CW-1:0] cnt;
        logic          fin;
    } store_st_t;

    store_st_t st_d, st_q;
    logic      fire;

    assign fire = st_q.v && wr_ready;
    assign step = !st_q.v || wr_ready;

    always_comb begin
        st_d     = st_q;
        st_d.fin = 1'b0;
        if (fire) begin
            if (st_q.cnt == CW'(TOTAL - 1)) begin
                st_d.cnt = '0;
                st_d.fin = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (step) begin
            st_d.v = in_v;
            st_d.a = in_a;
            st_d.d = a_data + b_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en   = st_q.v;
    assign wr_addr = st_q.a;
    assign wr_data = st_q.d;
    assign done    = st_q.fin;

    // R5
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_ready |=> wr_en && $stable(wr_addr) && $stable(wr_data));
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(wr_en && wr_ready));
endmodule

// File: rtl/mxadd_pipe.sv
module mxadd_pipe #(
    parameter int N  = 4,
    parameter int DW = 16,
    localparam int LGN   = $clog2(N),
    localparam int AW    = 2 * LGN,
    localparam int TOTAL = N * N,
    localparam int RDL   = mxadd_pkg::RD_LAT_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           id_valid,
    output logic           id_ready,
    input  logic [LGN-1:0] gid0,
    input  logic [LGN-1:0] gid1,
    output logic           rd_step,
    output logic           rda_en,
    output logic [AW-1:0]  rda_addr,
    input  logic [DW-1:0]  rda_data,
    output logic           rdb_en,
    output logic [AW-1:0]  rdb_addr,
    input  logic [DW-1:0]  rdb_data,
    output logic           wr_en,
    output logic [AW-1:0]  wr_addr,
    output logic [DW-1:0]  wr_data,
    input  logic           wr_ready,
    output logic           done
);
    logic          step;
    logic          s0_v;
    logic [AW-1:0] s0_a;
    logic          s2_v;
    logic [AW-1:0] s2_a;

    mxadd_addr #(.N(N)) u_addr (
        .clk(clk), .rst_n(rst_n), .step(step), .id_valid(id_valid),
        .gid0(gid0), .gid1(gid1), .s_valid(s0_v), .s_addr(s0_a)
    );

    mxadd_delay #(.AW(AW), .LAT(RDL)) u_delay (
        .clk(clk), .rst_n(rst_n), .step(step), .in_v(s0_v), .in_a(s0_a),
        .out_v(s2_v), .out_a(s2_a)
    );

    mxadd_store #(.DW(DW), .AW(AW), .TOTAL(TOTAL)) u_store (
        .clk(clk), .rst_n(rst_n), .in_v(s2_v), .in_a(s2_a),
        .a_data(rda_data), .b_data(rdb_data), .wr_ready(wr_ready),
        .step(step), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done)
    );

    assign id_ready = step;
    assign rd_step  = step;
    assign rda_en   = s0_v;
    assign rda_addr = s0_a;
    assign rdb_en   = s0_v;
    assign rdb_addr = s0_a;

    // R1
    accept_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid && id_ready |=> rda_en && rdb_en
            && rda_addr == {$past(gid1), $past(gid0)}
            && rdb_addr == {$past(gid1), $past(gid0)});
    // R5
    stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_ready |-> !id_ready && !rd_step);
endmodule

// File: tb/tb_mxadd_pipe.sv
`timescale 1ns/1ps
module tb_mxadd_pipe;
    localparam int N = 4, DW = 8, LGN = 2, AW = 4, TOT = 16;

    logic clk = 0, rst_n = 0;
    logic id_valid = 0, wr_ready = 1;
    logic [LGN-1:0] gid0 = 0, gid1 = 0;
    logic id_ready, rd_step, rda_en, rdb_en, wr_en, done;
    logic [AW-1:0] rda_addr, rdb_addr, wr_addr;
    logic [DW-1:0] rda_data, rdb_data, wr_data, pa, pb;

    int checks = 0, errors = 0, cyc = 0;
    int acc_total = 0, wr_total = 0, iss_total = 0, done_cnt = 0;
    int exp_idx [256];
    int acc_cyc [256];
    bit bp_mode = 0, phase0 = 1, fin_pending = 0, reported = 0;
    bit prev_stall = 0;
    logic [AW-1:0] prev_addr;
    logic [DW-1:0] prev_data;
    logic [7:0] lfsr = 8'hA5;

    always #5 clk = ~clk;

    mxadd_pipe #(.N(N), .DW(DW)) dut (.*);

    function automatic logic [DW-1:0] mem_a(input int k);
        return DW'(k * 7 + 3);
    endfunction
    function automatic logic [DW-1:0] mem_b(input int k);
        return DW'(k * 13 + 200);
    endfunction

    // Operand memories: two-step pipeline gated by rd_step (R4).
    always @(posedge clk) begin
        if (rd_step) begin
            pa <= mem_a(int'(rda_addr)); rda_data <= pa;
            pb <= mem_b(int'(rdb_addr)); rdb_data <= pb;
        end
    end

    initial forever begin
        @(posedge clk); #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        wr_ready = bp_mode ? lfsr[0] : 1'b1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        end
    endtask

    // Monitor, away from the active edge.
    always @(negedge clk) if (rst_n) begin
        bit exp_done;
        cyc++;
        exp_done = fin_pending;
        fin_pending = 0;
        if (done || exp_done) chk(done == exp_done, "R7 done pulse", int'(done), int'(exp_done));
        if (done) done_cnt++;
        if (prev_stall) begin
            chk(wr_en && wr_addr == prev_addr && wr_data == prev_data,
                "R5 held write addr", int'(wr_addr), int'(prev_addr));
        end
        prev_stall = wr_en && !wr_ready;
        prev_addr  = wr_addr;
        prev_data  = wr_data;
        if (prev_stall) chk(!id_ready && !rd_step, "R5 stall stops intake", int'(id_ready), 0);
        if (phase0) chk(id_ready == 1'b1, "R3 ready without back-pressure", int'(id_ready), 1);
        if (rda_en && rd_step) begin
            chk(rda_addr == AW'(exp_idx[iss_total]) && rdb_addr == AW'(exp_idx[iss_total]),
                "R1 read address", int'(rda_addr), exp_idx[iss_total]);
            iss_total++;
        end
        if (wr_en && wr_ready) begin
            int k;
            k = exp_idx[wr_total];
            chk(wr_addr == AW'(k), "R6 write order/address", int'(wr_addr), k);
            chk(wr_data == DW'(mem_a(k) + mem_b(k)), "R2 sum",
                int'(wr_data), int'(DW'(mem_a(k) + mem_b(k))));
            if (phase0) chk(cyc - acc_cyc[wr_total] == 4, "R3 latency",
                            cyc - acc_cyc[wr_total], 4);
            wr_total++;
            if (wr_total % TOT == 0) fin_pending = 1;
        end
        if (id_valid && id_ready) begin
            exp_idx[acc_total] = int'(gid1) * N + int'(gid0);
            acc_cyc[acc_total] = cyc;
            acc_total++;
        end
    end

    task automatic send(input int c, input int r);
        bit a;
        gid0 = LGN'(c); gid1 = LGN'(r); id_valid = 1;
        do begin
            @(negedge clk); a = id_ready;
            @(posedge clk); #1;
        end while (!a);
        id_valid = 0;
    endtask

    task automatic drain();
        while (wr_total != acc_total) @(posedge clk);
        repeat (6) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        report();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!wr_en && !rda_en && !rdb_en && !done, "R8 reset outputs low", int'(wr_en), 0);
        chk(id_ready == 1'b1, "R8 reset ready", int'(id_ready), 1);
        @(posedge clk); #1; rst_n = 1;
        @(negedge clk);
        chk(!wr_en && !done, "R8 after reset", int'(wr_en), 0);
        @(posedge clk); #1;
        // Sweep 1: row-major, back to back, no back-pressure (R3).
        id_valid = 1;
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                gid0 = LGN'(c); gid1 = LGN'(r);
                @(posedge clk); #1;
            end
        id_valid = 0;
        drain();
        phase0 = 0;
        chk(done_cnt == 1, "R7 one pulse per sweep", done_cnt, 1);
        // Sweep 2: column-major with gaps and back-pressure (R5, R6).
        bp_mode = 1;
        for (int c = 0; c < N; c++)
            for (int r = 0; r < N; r++) begin
                if ((c * N + r) % 3 == 2) begin @(posedge clk); #1; end
                send(c, r);
            end
        drain();
        chk(done_cnt == 2, "R7 one pulse per sweep", done_cnt, 2);
        // Sweep 3: reverse order under back-pressure.
        for (int k = TOT - 1; k >= 0; k--) send(k % N, k / N);
        bp_mode = 0;
        drain();
        chk(done_cnt == 3, "R7 one pulse per sweep", done_cnt, 3);
        chk(wr_total == acc_total && acc_total == 3 * TOT, "R5 no loss or duplication",
            wr_total, 3 * TOT);
        chk(iss_total == acc_total, "R4 one read per identifier", iss_total, acc_total);
        report();
        $finish;
    end
endmodule